// File: doc/BRIEF.md
# Integer ALU with Address Modes

This block is the integer and address arithmetic unit of a signal-processing core. Each cycle it may accept one operation: two 32-bit operands, a 4-bit opcode and three option bits. One clock edge later it presents a registered result, a result-write strobe and four status flags: zero, negative, overflow and carry. The operation set covers add and subtract, right-only shifts, a rotate in either direction, bitwise logic, absolute value, minimum, maximum and compare.

The same adder also steps data addresses. With the circular option, an add keeps the pointer inside a buffer that a base and a length describe. With the bit-reverse option, carries ripple from the most significant bit downward, which produces the scrambled index order an FFT needs.

A combinational condition evaluator reads the registered flags and tests a requested branch condition. It covers equal, less-than and less-or-equal, their negations, and signed or unsigned interpretation.

Top module: `ialu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, `res_data` becomes 0, all four flags become 0 and `res_wr` becomes 0.
- R2: Opcode 0 (add) and opcode 1 (subtract, A minus B) update `res_data` one edge after the operation is accepted, with `res_wr`=1. Z is set when the result is zero and N is the result MSB. V flags signed overflow. C is the carry out of A+B; for subtract, C is the carry out of A+~B+1, so C=1 means no borrow.
- R3: Opcode 5 (A AND NOT B), opcode 6 (NOT A), opcode 7 (OR) and opcode 8 (XOR) write their bitwise result, set Z and N from it, and clear V and C.
- R4: Opcode 2 (arithmetic right shift) and opcode 3 (logical right shift) shift A right by B, with B read as an unsigned count. A count of 32 or more gives all sign bits for the arithmetic shift and all zeros for the logical shift. V and C are cleared.
- R5: Opcode 4 rotates A. B is read as a signed amount: a positive value rotates left by B mod 32, and a negative value rotates right by |B| mod 32. V and C are cleared.
- R6: Opcode 9 writes |A|. For A=0x80000000 it writes 0x80000000 and sets V. For every other A, V is cleared. C is cleared.
- R7: Opcode 10 (minimum) and opcode 11 (maximum) compare A and B as signed numbers, or as unsigned numbers when `opt_uns`=1. V and C are cleared.
- R8: Opcode 12 (compare) sets the flags exactly as a subtract of the same operands would. It does not change `res_data`, and `res_wr` is 0 on the following cycle.
- R9: Opcode 0 with `opt_circ`=1 computes S=A+B. If S is at least base+length, it writes S−length. If S is below base, it writes S+length. Otherwise it writes S. This holds when |B| is at most the length. Z and N follow the result, and V and C are cleared. This option takes precedence over `opt_brev`.
- R10: Opcode 0 with `opt_brev`=1 and `opt_circ`=0 adds with carries that propagate from bit 31 toward bit 0. Z and N follow the result, and V and C are cleared.
- R11: `cond_true` is evaluated combinationally from the registered flags. Bits [1:0] of `cond_sel` choose EQ (0, Z), LT (1), LE (2, LT or Z) or always (3). Bit 2 negates the choice, which gives NEQ, NLT, NLE and never. LT is N XOR V when `cond_uns`=0, and NOT C when `cond_uns`=1.
- R12: A cycle with `op_valid`=0, or with an opcode from 13 to 15, leaves `res_data` and the flags unchanged and gives `res_wr`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation select |
| opt_uns | input | 1 | Unsigned interpretation for minimum and maximum |
| opt_circ | input | 1 | Circular-buffer wrap on add |
| opt_brev | input | 1 | Reverse-carry add |
| opnd_a | input | 32 | First operand or address |
| opnd_b | input | 32 | Second operand, step or shift amount |
| circ_base | input | 32 | Circular buffer base address |
| circ_len | input | 32 | Circular buffer length |
| cond_sel | input | 3 | Branch condition select |
| cond_uns | input | 1 | Unsigned interpretation for LT and LE |
| res_data | output | 32 | Registered result |
| res_wr | output | 1 | The result register was written by the last operation |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| cond_true | output | 1 | The selected condition holds on the current flags |

## Verification
The bench builds the block with its default data width of 32, so the saturation threshold of the shifts, the rotate wrap at 32 and the 0x80000000 corner of the absolute value all fall on the real boundaries. Random address runs draw buffer lengths from 1 to 64 and steps up to the full length in both directions, which reaches both wrap edges of the circular mode. A reverse-carry walk with a step of 0x80 covers the FFT index order. After selected operations, all eight condition codes are swept in both signed and unsigned forms.

// File: rtl/ialu_pkg.sv
// Package: shared opcode, condition and flag types for the integer ALU.
// Assumes the opcode field is 4 bits and the condition field is 3 bits.
package ialu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ASR  = 4'd2,
        OP_LSR  = 4'd3,
        OP_ROT  = 4'd4,
        OP_ANDN = 4'd5,
        OP_NOT  = 4'd6,
        OP_OR   = 4'd7,
        OP_XOR  = 4'd8,
        OP_ABS  = 4'd9,
        OP_MIN  = 4'd10,
        OP_MAX  = 4'd11,
        OP_CMP  = 4'd12
    } ialu_op_e;

    // Shift unit variant select
    typedef enum logic [1:0] {
        SH_LSR = 2'd0,
        SH_ASR = 2'd1,
        SH_ROT = 2'd2
    } ialu_sh_e;

    // Condition base codes; bit 2 of the select negates
    localparam logic [1:0] CND_EQ  = 2'd0;
    localparam logic [1:0] CND_LT  = 2'd1;
    localparam logic [1:0] CND_LE  = 2'd2;
    localparam logic [1:0] CND_ALW = 2'd3;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } ialu_flags_t;
endpackage

// File: rtl/ialu_shift.sv
// Module: right shifts and bidirectional rotate.
// A right shift by a count of DW or more saturates. The rotate amount is the
// low bits of amt: a left rotate by amt mod DW equals a right rotate by
// (-amt) mod DW, so both directions share one left rotator.
// Assumes DW is a power of two.
module ialu_shift #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]       val,
    input  logic [DW-1:0]       amt,
    input  ialu_pkg::ialu_sh_e  kind,
    output logic [DW-1:0]       out
);
    import ialu_pkg::*;

    localparam int SHW = $clog2(DW);

    logic            big;
    logic [SHW-1:0]  sh;
    logic [SHW:0]    back;

    // Split the amount into an in-range count and an overrange indication
    always_comb begin
        big  = |amt[DW-1:SHW];
        sh   = amt[SHW-1:0];
        back = (SHW+1)'(DW) - {1'b0, sh};
    end

    // Select the shift variant
    always_comb begin
        unique case (kind)
            SH_LSR:  out = big ? '0 : (val >> sh);
            SH_ASR:  out = big ? {DW{val[DW-1]}} : DW'($signed(val) >>> sh);
            SH_ROT:  out = (val << sh) | (val >> back);
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/ialu_addr.sv
// Module: address stepping for the ALU add path.
// Circular mode folds addr+step back into [base, base+len). This needs
// |step| <= len and base+len not wrapping past the top of the address range.
// Reverse-carry mode adds with carries moving from MSB to LSB.
// Circular mode takes precedence when both modes are requested.
module ialu_addr #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] base,
    input  logic [DW-1:0] len,
    input  logic          circ,
    output logic [DW-1:0] out
);
    logic [DW-1:0] addr_r, step_r, sum_r, sum_b, lin, limit;

    // Mirror the operands and the reversed sum bit by bit
    for (genvar i = 0; i < DW; i++) begin : g_mirror
        assign addr_r[i] = addr[DW-1-i];
        assign step_r[i] = step[DW-1-i];
        assign sum_b[i]  = sum_r[DW-1-i];
    end

    // Reverse-carry sum formed by an ordinary add on the mirrored values
    always_comb sum_r = addr_r + step_r;

    // Circular fold of the linear sum
    always_comb begin
        lin   = addr + step;
        limit = base + len;
        if (!circ)
            out = sum_b;
        else if (lin >= limit)
            out = lin - len;
        else if (lin < base)
            out = lin + len;
        else
            out = lin;
    end
endmodule

// File: rtl/ialu_cond.sv
// Module: branch condition evaluation over the registered flags.
// sel[1:0] picks EQ, LT, LE or always; sel[2] negates the pick.
// LT uses N^V when signed and !C when unsigned; C=1 means no borrow.
module ialu_cond (
    input  ialu_pkg::ialu_flags_t flg,
    input  logic [2:0]            sel,
    input  logic                  uns,
    output logic                  hit
);
    import ialu_pkg::*;

    logic lt, base_hit;

    // Evaluate the base condition, then apply the negation bit
    always_comb begin
        lt = uns ? !flg.c : (flg.n ^ flg.v);
        unique case (sel[1:0])
            CND_EQ:  base_hit = flg.z;
            CND_LT:  base_hit = lt;
            CND_LE:  base_hit = lt | flg.z;
            default: base_hit = 1'b1;
        endcase
        hit = base_hit ^ sel[2];
    end
endmodule

// File: rtl/ialu_core.sv
// Module: integer ALU with circular and reverse-carry address modes.
// One operation per cycle. Result, write strobe and flags are registered.
// The condition output reads the registered flags combinationally.
// Opcodes 13 to 15 and idle cycles leave all state unchanged.
module ialu_core #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic          opt_uns,
    input  logic          opt_circ,
    input  logic          opt_brev,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] circ_base,
    input  logic [DW-1:0] circ_len,
    input  logic [2:0]    cond_sel,
    input  logic          cond_uns,
    output logic [DW-1:0] res_data,
    output logic          res_wr,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_v,
    output logic          flag_c,
    output logic          cond_true
);
    import ialu_pkg::*;

    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    ialu_op_e      op;
    ialu_sh_e      sh_kind;
    ialu_flags_t   flg_q, flg_d;
    logic [DW-1:0] sh_out, addr_out, add_b, sum, neg_a, nxt;
    logic          cout, a_lt_b, known, use_addr;

    assign op = ialu_op_e'(op_code);

    // Pick the shift variant from the opcode
    always_comb begin
        unique case (op)
            OP_ASR:  sh_kind = SH_ASR;
            OP_ROT:  sh_kind = SH_ROT;
            default: sh_kind = SH_LSR;
        endcase
    end

    ialu_shift #(.DW(DW)) i_shift (
        .val (opnd_a),
        .amt (opnd_b),
        .kind(sh_kind),
        .out (sh_out)
    );

    ialu_addr #(.DW(DW)) i_addr (
        .addr(opnd_a),
        .step(opnd_b),
        .base(circ_base),
        .len (circ_len),
        .circ(opt_circ),
        .out (addr_out)
    );

    // Shared adder: A+B for add, A+~B+1 for subtract and compare
    always_comb begin
        add_b       = (op == OP_ADD) ? opnd_b : ~opnd_b;
        {cout, sum} = {1'b0, opnd_a} + {1'b0, add_b} + {{DW{1'b0}}, op != OP_ADD};
        neg_a       = '0 - opnd_a;
        a_lt_b      = opt_uns ? (opnd_a < opnd_b) : ($signed(opnd_a) < $signed(opnd_b));
        use_addr    = opt_circ | opt_brev;
    end

    // Per-opcode next result and flags
    always_comb begin
        known   = 1'b1;
        flg_d.v = 1'b0;
        flg_d.c = 1'b0;
        nxt     = res_data;
        unique case (op)
            OP_ADD, OP_SUB, OP_CMP: begin
                nxt = (op == OP_ADD && use_addr) ? addr_out : sum;
                if (!(op == OP_ADD && use_addr)) begin
                    flg_d.c = cout;
                    flg_d.v = (opnd_a[DW-1] == add_b[DW-1]) && (sum[DW-1] != opnd_a[DW-1]);
                end
            end
            OP_ASR, OP_LSR, OP_ROT: nxt = sh_out;
            OP_ANDN: nxt = opnd_a & ~opnd_b;
            OP_NOT:  nxt = ~opnd_a;
            OP_OR:   nxt = opnd_a | opnd_b;
            OP_XOR:  nxt = opnd_a ^ opnd_b;
            OP_ABS: begin
                nxt     = opnd_a[DW-1] ? neg_a : opnd_a;
                flg_d.v = (opnd_a == MOST_NEG);
            end
            OP_MIN:  nxt = a_lt_b ? opnd_a : opnd_b;
            OP_MAX:  nxt = a_lt_b ? opnd_b : opnd_a;
            default: known = 1'b0;
        endcase
        flg_d.z = (nxt == '0);
        flg_d.n = nxt[DW-1];
    end

    // Result, write strobe and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_data <= '0;
            res_wr   <= 1'b0;
            flg_q    <= '0;
        end else begin
            res_wr <= op_valid && known && (op != OP_CMP);
            if (op_valid && known) begin
                flg_q <= flg_d;
                if (op != OP_CMP)
                    res_data <= nxt;
            end
        end
    end

    assign flag_z = flg_q.z;
    assign flag_n = flg_q.n;
    assign flag_v = flg_q.v;
    assign flag_c = flg_q.c;

    ialu_cond i_cond (
        .flg(flg_q),
        .sel(cond_sel),
        .uns(cond_uns),
        .hit(cond_true)
    );
endmodule

// File: rtl/ialu_core_chk.sv
// Module: property checker for ialu_core, attached with bind.
// Assumes the opcode values listed in the requirements.
module ialu_core_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic          opt_circ,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic [DW-1:0] circ_base,
    input logic [DW-1:0] circ_len,
    input logic [2:0]    cond_sel,
    input logic [DW-1:0] res_data,
    input logic          res_wr,
    input logic          flag_z,
    input logic          flag_n,
    input logic          flag_v,
    input logic          flag_c,
    input logic          cond_true
);
    logic in_buf, small_step;

    // Qualify circular operations that start inside the buffer with a legal step
    always_comb begin
        in_buf     = (opnd_a >= circ_base) && ((opnd_a - circ_base) < circ_len);
        small_step = ($signed(opnd_b) >= 0) ? (opnd_b <= circ_len) : (('0 - opnd_b) <= circ_len);
    end

    p_reset_r1: assert property (@(posedge clk) !rst_n |=> !res_wr && res_data == '0);

    p_logic_vc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code inside {4'd5, 4'd6, 4'd7, 4'd8}) |=> !flag_v && !flag_c);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd9 && opnd_a[DW-1] == 1'b0) |=> !flag_v && !flag_n);

    p_cmp_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd12) |=> !res_wr && $stable(res_data));

    p_circ_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0 && opt_circ && in_buf && small_step)
        |=> (res_data >= $past(circ_base)) && ((res_data - $past(circ_base)) < $past(circ_len)));

    p_cond_eq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd0) |-> cond_true == flag_z);

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !res_wr && $stable(res_data) && $stable({flag_z, flag_n, flag_v, flag_c}));
endmodule

bind ialu_core ialu_core_chk #(.DW(DW)) i_ialu_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .opt_circ (opt_circ),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .circ_base(circ_base),
    .circ_len (circ_len),
    .cond_sel (cond_sel),
    .res_data (res_data),
    .res_wr   (res_wr),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .cond_true(cond_true)
);

// File: tb/test_ialu_core.sv
// Bench: behavioural reference model compared after every operation cycle.
module test_ialu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic        opt_uns = 1'b0, opt_circ = 1'b0, opt_brev = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, circ_base = '0, circ_len = '0;
    logic [2:0]  cond_sel = '0;
    logic        cond_uns = 1'b0;
    logic [31:0] res_data;
    logic        res_wr, flag_z, flag_n, flag_v, flag_c, cond_true;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // Model state
    logic [31:0] m_res = '0;
    logic        m_wr = 0, m_z = 0, m_n = 0, m_v = 0, m_c = 0;

    always #10 clk = ~clk;

    ialu_core i_ialu_core (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opt_uns(opt_uns), .opt_circ(opt_circ), .opt_brev(opt_brev),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .circ_base(circ_base), .circ_len(circ_len),
        .cond_sel(cond_sel), .cond_uns(cond_uns), .res_data(res_data), .res_wr(res_wr),
        .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v), .flag_c(flag_c),
        .cond_true(cond_true)
    );

    task automatic check(string tag, logic [35:0] act, logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model of one accepted operation
    task automatic model(logic vld, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                         logic uns, logic circ, logic brev, logic [31:0] base, logic [31:0] len);
        logic [31:0] r;
        logic v, c, wr;
        longint la, lb, s;
        la = longint'($signed(a));
        lb = longint'($signed(b));
        v = 0; c = 0; wr = 1; r = 0;
        if (!vld || op > 4'd12) begin
            m_wr = 0;
            return;
        end
        case (op)
            4'd0: begin
                if (circ) begin
                    s = longint'(a) + lb;
                    if (s >= longint'(base) + longint'(len)) s -= longint'(len);
                    else if (s < longint'(base)) s += longint'(len);
                    r = s[31:0];
                end else if (brev) begin
                    int cy = 0;
                    for (int i = 31; i >= 0; i--) begin
                        int t = int'(a[i]) + int'(b[i]) + cy;
                        r[i] = t[0];
                        cy = t / 2;
                    end
                end else begin
                    s = longint'(a) + longint'(b);
                    r = s[31:0];
                    c = s[32];
                    v = (la + lb > 64'sd2147483647) || (la + lb < -64'sd2147483648);
                end
            end
            4'd1, 4'd12: begin
                r = a - b;
                c = (a >= b);
                v = (la - lb > 64'sd2147483647) || (la - lb < -64'sd2147483648);
                if (op == 4'd12) wr = 0;
            end
            4'd2: r = (b >= 32) ? {32{a[31]}} : 32'($signed(a) >>> b);
            4'd3: r = (b >= 32) ? 32'd0 : a >> b;
            4'd4: begin
                longint k = (lb >= 0) ? lb % 32 : (-lb) % 32;
                r = a;
                for (int i = 0; i < k; i++)
                    r = (lb >= 0) ? {r[30:0], r[31]} : {r[0], r[31:1]};
            end
            4'd5: r = a & ~b;
            4'd6: r = ~a;
            4'd7: r = a | b;
            4'd8: r = a ^ b;
            4'd9: begin
                r = (la < 0) ? 32'(-la) : a;
                v = (a == 32'h8000_0000);
            end
            4'd10, 4'd11: begin
                bit lt = uns ? (a < b) : (la < lb);
                r = ((op == 4'd10) == lt) ? a : b;
            end
            default: ;
        endcase
        m_wr = wr;
        if (wr) m_res = r;
        m_z = (r == 0); m_n = r[31]; m_v = v; m_c = c;
    endtask

    function automatic logic cond_model(logic [2:0] sel, logic uns);
        logic lt, h;
        lt = uns ? !m_c : (m_n ^ m_v);
        case (sel[1:0])
            2'd0: h = m_z;
            2'd1: h = lt;
            2'd2: h = lt | m_z;
            default: h = 1'b1;
        endcase
        return h ^ sel[2];
    endfunction

    // Drive one operation at a falling edge, compare at the next falling edge
    task automatic run(string tag, logic vld, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic uns = 0, logic circ = 0, logic brev = 0,
                       logic [31:0] base = 0, logic [31:0] len = 0);
        op_valid = vld; op_code = op; opnd_a = a; opnd_b = b;
        opt_uns = uns; opt_circ = circ; opt_brev = brev; circ_base = base; circ_len = len;
        model(vld, op, a, b, uns, circ, brev, base, len);
        @(posedge clk);
        @(negedge clk);
        check(tag, {res_data, res_wr, flag_z, flag_n, flag_v},
                   {m_res, m_wr, m_z, m_n, m_v});
        check(tag, {35'd0, flag_c}, {35'd0, m_c});
    endtask

    // Sweep all condition codes in both interpretations against the model flags
    task automatic sweep_cond();
        for (int u = 0; u < 2; u++) begin
            for (int s = 0; s < 8; s++) begin
                cond_sel = 3'(s); cond_uns = u[0];
                #1;
                check("R11 cond", {35'd0, cond_true}, {35'd0, cond_model(3'(s), u[0])});
            end
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {res_data, res_wr, flag_z, flag_n, flag_v}, 36'd0);
        check("R1 reset carry", {35'd0, flag_c}, 36'd0);
        rst_n = 1'b1;

        // R2 add and subtract corners
        run("R2 add ovf", 1, 4'd0, 32'h7fff_ffff, 32'd1);      sweep_cond();
        run("R2 add carry", 1, 4'd0, 32'hffff_ffff, 32'd1);    sweep_cond();
        run("R2 sub borrow", 1, 4'd1, 32'd5, 32'd7);           sweep_cond();
        run("R2 sub ovf", 1, 4'd1, 32'h8000_0000, 32'd1);      sweep_cond();
        // R8 compare keeps result
        run("R8 cmp eq", 1, 4'd12, 32'd9, 32'd9);              sweep_cond();
        run("R8 cmp lt", 1, 4'd12, 32'hffff_fff0, 32'd3);      sweep_cond();
        // R3 logic
        run("R3 andn", 1, 4'd5, 32'hf0f0_ffff, 32'h0000_00ff);
        run("R3 not", 1, 4'd6, 32'hffff_ffff, 32'd0);
        run("R3 or", 1, 4'd7, 32'h8000_0000, 32'h1);
        run("R3 xor", 1, 4'd8, 32'h1234_5678, 32'h1234_5678);
        // R4 shifts
        run("R4 asr", 1, 4'd2, 32'h8000_0000, 32'd4);
        run("R4 asr sat", 1, 4'd2, 32'h8000_0000, 32'd40);
        run("R4 lsr", 1, 4'd3, 32'h8000_0000, 32'd31);
        run("R4 lsr sat", 1, 4'd3, 32'hffff_ffff, 32'd32);
        // R5 rotate both ways
        run("R5 rot left", 1, 4'd4, 32'h8000_0001, 32'd4);
        run("R5 rot right", 1, 4'd4, 32'h8000_0001, -32'sd4);
        run("R5 rot zero", 1, 4'd4, 32'hdead_beef, 32'd32);
        // R6 absolute value
        run("R6 abs neg", 1, 4'd9, -32'sd17, 32'd0);
        run("R6 abs min", 1, 4'd9, 32'h8000_0000, 32'd0);
        // R7 min/max
        run("R7 min s", 1, 4'd10, 32'hffff_ffff, 32'd1, 0);
        run("R7 min u", 1, 4'd10, 32'hffff_ffff, 32'd1, 1);
        run("R7 max s", 1, 4'd11, 32'hffff_ffff, 32'd1, 0);
        run("R7 max u", 1, 4'd11, 32'hffff_ffff, 32'd1, 1);
        // R9 circular wrap at both ends
        run("R9 circ top", 1, 4'd0, 32'd1030, 32'd4, 0, 1, 1, 32'd1024, 32'd8);
        run("R9 circ bottom", 1, 4'd0, 32'd1024, -32'sd1, 0, 1, 0, 32'd1024, 32'd8);
        run("R9 circ mid", 1, 4'd0, 32'd1025, 32'd2, 0, 1, 0, 32'd1024, 32'd8);
        // R10 reverse-carry walk with step 0x80
        begin
            logic [31:0] p = 0;
            for (int i = 0; i < 8; i++) begin
                run("R10 brev", 1, 4'd0, p, 32'h80, 0, 0, 1);
                p = res_data;
            end
        end
        // R12 idle and unknown opcodes
        run("R12 idle", 0, 4'd0, 32'd1, 32'd1);
        run("R12 op13", 1, 4'd13, 32'd1, 32'd1);
        run("R12 op15", 1, 4'd15, 32'd0, 32'd0);

        // Random mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op = 4'($urandom_range(0, 15));
            logic [31:0] a = $urandom(), b = $urandom();
            if (i % 3 == 0) b = 32'($urandom_range(0, 40));
            run("R2 random", ($urandom_range(0, 7) != 0), op, a, b, 1'($urandom()), 0, 0);
            if (i % 50 == 0) sweep_cond();
        end
        // Random circular addressing
        for (int i = 0; i < 300; i++) begin
            int len = $urandom_range(1, 64);
            logic [31:0] base = 32'($urandom_range(64, 100000));
            logic [31:0] a = base + 32'($urandom_range(0, len - 1));
            int st = $urandom_range(0, 2 * len) - len;
            run("R9 random", 1, 4'd0, a, 32'(st), 0, 1, 1'($urandom()), base, 32'(len));
        end

        op_valid = 0;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule